// File: doc/BRIEF.md
# Circular Overlapped Register Window File

This block holds the register file of a RISC core that passes procedure arguments through overlapping register windows instead of saving registers to memory. It has 74 physical registers. A procedure always addresses 32 logical registers with 5-bit numbers. Logical 0 to 9 are globals that every procedure shares. Logical 10 to 15 are the incoming set, which the caller also sees. Logical 16 to 25 are private locals. Logical 26 to 31 are the outgoing set, which the callee also sees.

The core changes the active window through a call strobe and a return strobe. The window pointer moves one window forward on a call and one window back on a return, modulo four. The ring is circular: the outgoing set of the last window is the incoming set of the first window.

The block also keeps a saturating count of nested windows. A call that would nest beyond three windows raises an overflow flag, and a return with no nested window raises an underflow flag. These flags let the core trap and spill or fill a window. The window pointer still moves on these events.

The block has two combinational read ports and one clocked write port. Each port maps its logical number to a physical register using the window pointer as it stands in that cycle.

Top module: `rwin_file`

## Requirements
- R1: After reset, `cwp_o` is 0, `depth_o` is 0, and both `ovf_o` and `unf_o` are 0 while no strobe is active.
- R2: Logical registers 1 to 9 reach the same physical register in every window. A value written there in one window reads back unchanged in all four windows.
- R3: In window w, logical 16 to 25 reach private locals that no other window can see. Logical r from 10 to 31 maps to physical 10 + ((16·w + r − 10) mod 64).
- R4: Logical 26 to 31 of window w are the same registers as logical 10 to 15 of window (w+1) mod 4. This includes window 3, whose outgoing set is logical 10 to 15 of window 0.
- R5: Logical register 0 always reads as 0 on both read ports, and a write to logical 0 has no effect.
- R6: Read ports A and B are combinational and independent. Each returns the register its own address selects in the current window, within the same cycle.
- R7: A cycle with `call_i` high moves `cwp_o` to (cwp+1) mod 4 on the next edge. If `depth_o` is below 3, it also raises `depth_o` by 1. A cycle with no strobe changes neither.
- R8: A cycle with `ret_i` high and `call_i` low moves `cwp_o` to (cwp−1) mod 4 on the next edge. If `depth_o` is above 0, it also lowers `depth_o` by 1.
- R9: In a cycle where `call_i` is high and `depth_o` is 3, `ovf_o` is high in that cycle. The window pointer still advances, and `depth_o` stays at 3.
- R10: In a cycle where `ret_i` is high, `call_i` is low and `depth_o` is 0, `unf_o` is high in that cycle. The window pointer still moves back, and `depth_o` stays at 0.
- R11: When `call_i` and `ret_i` are both high, the call takes effect and the return is ignored, so `unf_o` stays low.
- R12: A write in the same cycle as a call uses the window that was active before the call.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| call_i | input | 1 | Call strobe, advances the window |
| ret_i | input | 1 | Return strobe, retreats the window |
| rd_a_addr | input | 5 | Logical register number, read port A |
| rd_a_data | output | 32 | Read data, port A |
| rd_b_addr | input | 5 | Logical register number, read port B |
| rd_b_data | output | 32 | Read data, port B |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Logical register number for the write |
| wr_data | input | 32 | Write data |
| cwp_o | output | 2 | Current window pointer |
| depth_o | output | 2 | Saturating count of nested windows |
| ovf_o | output | 1 | Window overflow, valid in the strobe cycle |
| unf_o | output | 1 | Window underflow, valid in the strobe cycle |

## Verification
Some properties are checked on every cycle by assertions:
- the pointer steps on call and return, and holds when idle;
- the depth count holds at its limit after overflow or underflow;
- logical 0 reads as zero;
- the two read ports agree when they carry the same address.

Other behaviour can only be shown by the bench scenarios. This covers the mapping itself:
- the overlap of each outgoing set with the next window's incoming set;
- the wrap from window 3 to window 0;
- the privacy of locals;
- the use of the pre-call window by a write issued together with a call.

The bench writes every logical register in every window, then reads all 32 of them in all four windows on both ports. It compares each read against a shadow register file indexed by a physical number that the bench works out from the window layout.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
  localparam int LREG_W = 5;

  typedef logic [LREG_W-1:0] lreg_t;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_CALL = 2'd1,
    OP_RET  = 2'd2
  } win_op_e;
endpackage

// File: rtl/rwin_map.sv
module rwin_map
  import rwin_pkg::*;
#(
  parameter int NUM_GLB = 10,
  parameter int NUM_LOC = 10,
  parameter int NUM_SHR = 6,
  parameter int NUM_WIN = 4,
  parameter int CWP_W   = 2,
  parameter int PHYS_W  = 7
) (
  input  logic [CWP_W-1:0]  cwp,
  input  lreg_t             lreg,
  output logic [PHYS_W-1:0] preg
);
  localparam int STRIDE = NUM_LOC + NUM_SHR;
  localparam int RING   = STRIDE * NUM_WIN;

  int offs;

  always_comb begin
    offs = STRIDE * int'(cwp) + int'(lreg) - NUM_GLB;
    if (offs >= RING) offs = offs - RING;
    if (int'(lreg) < NUM_GLB) preg = PHYS_W'(lreg);
    else                      preg = PHYS_W'(NUM_GLB + offs);
  end
endmodule

// File: rtl/rwin_ptr.sv
module rwin_ptr
  import rwin_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int CWP_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             call_i,
  input  logic             ret_i,
  output logic [CWP_W-1:0] cwp_o,
  output logic [CWP_W-1:0] depth_o,
  output logic             ovf_o,
  output logic             unf_o
);
  localparam logic [CWP_W-1:0] LAST = CWP_W'(NUM_WIN - 1);

  win_op_e          op;
  logic             step_en;
  logic [CWP_W-1:0] cwp_q, cwp_d, dep_q, dep_d;

  always_comb begin
    op = call_i ? OP_CALL : (ret_i ? OP_RET : OP_IDLE);
    step_en = (op != OP_IDLE);
    cwp_d = cwp_q;
    dep_d = dep_q;
    ovf_o = 1'b0;
    unf_o = 1'b0;
    case (op)
      OP_CALL: begin
        cwp_d = (cwp_q == LAST) ? '0 : cwp_q + 1'b1;
        if (dep_q == LAST) ovf_o = 1'b1;
        else               dep_d = dep_q + 1'b1;
      end
      OP_RET: begin
        cwp_d = (cwp_q == '0) ? LAST : cwp_q - 1'b1;
        if (dep_q == '0) unf_o = 1'b1;
        else             dep_d = dep_q - 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp_q <= '0;
      dep_q <= '0;
    end else if (step_en) begin
      cwp_q <= cwp_d;
      dep_q <= dep_d;
    end
  end

  assign cwp_o   = cwp_q;
  assign depth_o = dep_q;

  p_call_adv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    call_i |=> cwp_o == CWP_W'((int'($past(cwp_o)) + 1) % NUM_WIN));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!call_i && !ret_i) |=> ($stable(cwp_o) && $stable(depth_o)));

  p_ret_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !call_i) |=>
      cwp_o == CWP_W'((int'($past(cwp_o)) + NUM_WIN - 1) % NUM_WIN));

  p_ovf_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> depth_o == LAST);

  p_unf_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    unf_o |=> depth_o == '0);

  p_no_unf_on_call_r11: assert property (@(posedge clk) disable iff (!rst_n)
    call_i |-> !unf_o);
endmodule

// File: rtl/rwin_store.sv
module rwin_store #(
  parameter int NUM_PHYS = 74,
  parameter int PHYS_W   = 7,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PHYS_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PHYS_W-1:0] raddr_a,
  input  logic [PHYS_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] row [NUM_PHYS];

  assign row[0] = '0;

  for (genvar i = 1; i < NUM_PHYS; i++) begin : g_row
    logic              row_en;
    logic [DATA_W-1:0] row_q;

    assign row_en = we && (waddr == PHYS_W'(i));

    always_ff @(posedge clk) begin
      if (row_en) row_q <= wdata;
    end

    assign row[i] = row_q;
  end

  always_comb begin
    rdata_a = '0;
    rdata_b = '0;
    if (int'(raddr_a) < NUM_PHYS) rdata_a = row[raddr_a];
    if (int'(raddr_b) < NUM_PHYS) rdata_b = row[raddr_b];
  end
endmodule

// File: rtl/rwin_file.sv
module rwin_file
  import rwin_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_GLB = 10,
  parameter int NUM_LOC = 10,
  parameter int NUM_SHR = 6,
  parameter int NUM_WIN = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       call_i,
  input  logic                       ret_i,
  input  logic [4:0]                 rd_a_addr,
  output logic [DATA_W-1:0]          rd_a_data,
  input  logic [4:0]                 rd_b_addr,
  output logic [DATA_W-1:0]          rd_b_data,
  input  logic                       wr_en,
  input  logic [4:0]                 wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [$clog2(NUM_WIN)-1:0] cwp_o,
  output logic [$clog2(NUM_WIN)-1:0] depth_o,
  output logic                       ovf_o,
  output logic                       unf_o
);
  localparam int NUM_PHYS = NUM_GLB + (NUM_LOC + NUM_SHR) * NUM_WIN;
  localparam int PHYS_W   = $clog2(NUM_PHYS);
  localparam int CWP_W    = $clog2(NUM_WIN);

  logic [CWP_W-1:0]  cwp;
  logic [PHYS_W-1:0] pa, pb, pw;
  logic              we_phys;

  rwin_ptr #(.NUM_WIN(NUM_WIN), .CWP_W(CWP_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
    .cwp_o(cwp), .depth_o(depth_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  rwin_map #(.NUM_GLB(NUM_GLB), .NUM_LOC(NUM_LOC), .NUM_SHR(NUM_SHR),
             .NUM_WIN(NUM_WIN), .CWP_W(CWP_W), .PHYS_W(PHYS_W)) u_map_a (
    .cwp(cwp), .lreg(rd_a_addr), .preg(pa)
  );

  rwin_map #(.NUM_GLB(NUM_GLB), .NUM_LOC(NUM_LOC), .NUM_SHR(NUM_SHR),
             .NUM_WIN(NUM_WIN), .CWP_W(CWP_W), .PHYS_W(PHYS_W)) u_map_b (
    .cwp(cwp), .lreg(rd_b_addr), .preg(pb)
  );

  // Write side maps with the pointer still in place during a call cycle (R12).
  rwin_map #(.NUM_GLB(NUM_GLB), .NUM_LOC(NUM_LOC), .NUM_SHR(NUM_SHR),
             .NUM_WIN(NUM_WIN), .CWP_W(CWP_W), .PHYS_W(PHYS_W)) u_map_w (
    .cwp(cwp), .lreg(wr_addr), .preg(pw)
  );

  assign we_phys = wr_en && (wr_addr != '0);

  rwin_store #(.NUM_PHYS(NUM_PHYS), .PHYS_W(PHYS_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .we(we_phys), .waddr(pw), .wdata(wr_data),
    .raddr_a(pa), .raddr_b(pb), .rdata_a(rd_a_data), .rdata_b(rd_b_data)
  );

  assign cwp_o = cwp;

  p_zero_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_addr == '0) |-> (rd_a_data == '0));

  p_ports_agree_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_addr == rd_b_addr) |-> (rd_a_data == rd_b_data));

  p_phys_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(pa) < NUM_PHYS) && (int'(pw) < NUM_PHYS));
endmodule

// File: tb/rwin_file_test.sv
`timescale 1ns/1ps
module rwin_file_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        call_i, ret_i, wr_en;
  logic [4:0]  rd_a_addr, rd_b_addr, wr_addr;
  logic [31:0] rd_a_data, rd_b_data, wr_data;
  logic [1:0]  cwp_o, depth_o;
  logic        ovf_o, unf_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [31:0] shadow [74];
  int exp_cwp = 0;
  int exp_dep = 0;

  always #2 clk = ~clk;

  rwin_file uut (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
    .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cwp_o(cwp_o), .depth_o(depth_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Physical register from the window layout: incoming, local, outgoing blocks.
  function automatic int phys_of(input int w, input int r);
    if (r < 10) return r;
    if (r < 16) return (w == 0) ? r : 26 + 16 * (w - 1) + (r - 10);
    if (r < 26) return 16 + 16 * w + (r - 16);
    return (w == 3) ? 10 + (r - 26) : 26 + 16 * w + (r - 26);
  endfunction

  task automatic cycle(input bit c, input bit rt, input bit we,
                       input int wa, input logic [31:0] wd, input string tag);
    bit eo, eu;
    @(negedge clk);
    call_i = c; ret_i = rt; wr_en = we; wr_addr = wa[4:0]; wr_data = wd;
    #1;
    eo = c && exp_dep == 3;
    eu = rt && !c && exp_dep == 0;
    if (c || rt) begin
      check(ovf_o == eo, {tag, " ovf"}, {31'd0, ovf_o}, {31'd0, eo});
      check(unf_o == eu, {tag, " unf"}, {31'd0, unf_o}, {31'd0, eu});
    end
    if (we && wa != 0) shadow[phys_of(exp_cwp, wa)] = wd;
    if (c) begin
      exp_cwp = (exp_cwp + 1) % 4;
      if (exp_dep < 3) exp_dep++;
    end else if (rt) begin
      exp_cwp = (exp_cwp + 3) % 4;
      if (exp_dep > 0) exp_dep--;
    end
    @(posedge clk);
    #1;
    call_i = 1'b0; ret_i = 1'b0; wr_en = 1'b0;
    if (c || rt) begin
      check(cwp_o == exp_cwp[1:0], {tag, " cwp"}, {30'd0, cwp_o}, exp_cwp);
      check(depth_o == exp_dep[1:0], {tag, " depth"}, {30'd0, depth_o}, exp_dep);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    string tag;
    for (int i = 0; i < 74; i++) shadow[i] = '0;
    rst_n = 1'b0; call_i = 1'b0; ret_i = 1'b0; wr_en = 1'b0;
    rd_a_addr = '0; rd_b_addr = '0; wr_addr = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check(cwp_o == 2'd0, "R1 cwp", {30'd0, cwp_o}, 0);
    check(depth_o == 2'd0, "R1 depth", {30'd0, depth_o}, 0);
    check(!ovf_o && !unf_o, "R1 flags", {30'd0, ovf_o, unf_o}, 0);

    // Write every logical register in every window (R5 covers writes to 0).
    // The fourth call is made at depth 3 (R9) and wraps the pointer to 0 (R7).
    for (int w = 0; w < 4; w++) begin
      for (int r = 0; r < 32; r++)
        cycle(0, 0, 1, r, 32'hA000_0000 | (w << 8) | r, "R3 write");
      cycle(1, 0, 0, 0, '0, (w == 3) ? "R9 call at depth 3" : "R7 call");
    end

    // Read sweep over all windows on both ports: R2, R3, R4, R5, R6.
    for (int w = 0; w < 4; w++) begin
      for (int r = 0; r < 32; r++) begin
        @(negedge clk);
        rd_a_addr = r[4:0];
        rd_b_addr = 5'(31 - r);
        #1;
        if (r == 0)               tag = "R5 zero read";
        else if (r < 10)          tag = "R2 global";
        else if (r >= 26 && w == 3) tag = "R4 wrap";
        else if (r >= 26 || r < 16) tag = "R4 overlap";
        else                      tag = "R3 local";
        check(rd_a_data == shadow[phys_of(exp_cwp, r)], {tag, " port A"},
              rd_a_data, shadow[phys_of(exp_cwp, r)]);
        check(rd_b_data == shadow[phys_of(exp_cwp, 31 - r)], "R6 port B",
              rd_b_data, shadow[phys_of(exp_cwp, 31 - r)]);
      end
      cycle(1, 0, 0, 0, '0, "R9 call saturated");
    end

    // Returns back to depth 0, then one more raises underflow: R8, R10.
    for (int k = 0; k < 3; k++) cycle(0, 1, 0, 0, '0, "R8 return");
    cycle(0, 1, 0, 0, '0, "R10 return at depth 0");

    // R11: both strobes at depth 0, call wins and there is no underflow.
    cycle(1, 1, 0, 0, '0, "R11 call with return");

    // R12: write the outgoing set while calling; the new window sees it as incoming.
    cycle(1, 0, 1, 27, 32'h5EED_1234, "R12 write with call");
    @(negedge clk);
    rd_a_addr = 5'd11;
    rd_b_addr = 5'd27;
    #1;
    check(rd_a_data == 32'h5EED_1234, "R12 incoming after call",
          rd_a_data, 32'h5EED_1234);
    check(rd_b_data == shadow[phys_of(exp_cwp, 27)], "R12 outgoing untouched",
          rd_b_data, shadow[phys_of(exp_cwp, 27)]);

    // R5: a write to logical 0 leaves it reading zero.
    cycle(0, 0, 1, 0, 32'hFFFF_FFFF, "R5 write zero");
    @(negedge clk);
    rd_a_addr = 5'd0;
    rd_b_addr = 5'd0;
    #1;
    check(rd_a_data == '0 && rd_b_data == '0, "R5 zero after write",
          rd_a_data | rd_b_data, '0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule